// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block turns a free-running reference clock into a one-cycle clock-enable pulse that fires once every N reference cycles. N comes from a small divisor field that software writes. The output can be gated on and off by one bit in a separate enable register. The position of that bit is a build-time parameter. A status register reports a pair of busy flags while a divisor change is waiting to take effect.

A valid divisor write is first parked in a pending slot. It is copied into the live divisor only at the end of the output period in progress, or on the next cycle if the output is gated off. Because of this, a running period is never cut short. Software is expected to poll busy before and after each divisor write.

The field is 5 bits wide by default. A build option adds a sixth bit. When that bit is set, the low five bits are multiplied by a fixed prescale of 64. A zero field always means the largest plain divisor, which is the field range plus one.

Top module: `clkdiv_gate`

## Requirements
- R1: After reset, `clk_en_o` is low, and reads of the status, divisor and enable registers all return 0 (divisor field 0, output gated off, not busy).
- R2: While enabled, `clk_en_o` is high for exactly one cycle in every N reference cycles. For a plain field value f in 1..(2^W − 1), N equals f, where W is the field width (5 by default). When f is 1, the output stays high.
- R3: A field value of 0 gives N = 2^W: 32 in the 5-bit build and 64 in the 6-bit build.
- R4: In the 6-bit build, when field bit 5 is set, N = 64 × field[4:0]. The value 0x20 gives N = 64.
- R5: A divisor write whose data has any bit set at or above position W is rejected. It raises no busy flag and leaves the divisor register value unchanged.
- R6: The enable register at word address 2 holds one bit at position `EN_BIT`. Writing 1 there enables the output and writing 0 gates it. All other written bits are ignored, and a read returns only that bit.
- R7: While gated off, no pulses appear and the period counter is held at zero. After the enable write, the first pulse is seen N+1 cycles after the cycle in which the write was presented.
- R8: The status register at word address 0 returns busy in bits 3 and 4 (value 0x18) from the cycle after an accepted divisor write until the cycle after the new divisor is applied. Otherwise it returns 0.
- R9: A pending divisor is applied at the terminal count of the current period. The pulse that ends that period keeps its old spacing. If the output is gated off, the divisor is applied on the next cycle.
- R10: A divisor write that arrives while busy is high is ignored.
- R11: A read request presented at word address 0, 1 (divisor) or 2 (enable) returns its data on `rdata_o` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Word address: 0 status, DIV_ADDR divisor, EN_ADDR enable |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data, valid the cycle after `rd_en_i` |
| clk_en_o | output | 1 | Divided, gated one-cycle clock-enable pulse |

## Verification
The following faults show up as wrong spacing of `clk_en_o` within one output period, and the per-cycle comparison against the reference model catches them there:
- a wrong live divisor;
- a misread prescale bit;
- a counter that is not cleared while gated.

A pending divisor that is applied too early shows up as a shortened final period, which the alignment check after the write measures. A busy flag that is stuck or that clears late shows up on the next status read, or as a later write being wrongly dropped, and this lasts until the next terminal count.

// File: rtl/cd_pkg.sv
package cd_pkg;
  // Status register bit positions of the two busy flags
  localparam int BUSY_LO = 3;
  localparam int BUSY_HI = 4;
  // Fixed word address of the status register
  localparam int STATUS_ADDR = 0;
endpackage

// File: rtl/cd_div_decode.sv
module cd_div_decode #(
  parameter int BASE_W   = 5,
  parameter int WIDE     = 0,
  parameter int PRE_LOG2 = 6,
  parameter int CNT_W    = 6,
  localparam int FIELD_W = BASE_W + WIDE
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [CNT_W-1:0]   n_o
);
  localparam int LIMIT = 1 << FIELD_W;

  generate
    if (WIDE != 0) begin : g_wide
      logic [BASE_W-1:0] low;
      assign low = field_i[BASE_W-1:0];
      always_comb begin
        if (field_i[BASE_W]) begin
          n_o = (low == '0) ? CNT_W'(LIMIT) : (CNT_W'(low) << PRE_LOG2);
        end else begin
          n_o = (field_i == '0) ? CNT_W'(LIMIT) : CNT_W'(field_i);
        end
      end
    end else begin : g_plain
      always_comb begin
        n_o = (field_i == '0) ? CNT_W'(LIMIT) : CNT_W'(field_i);
      end
    end
  endgenerate
endmodule

// File: rtl/cd_counter.sv
module cd_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] n_i,
  output logic             term_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pulse_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pulse_q;

  assign term_o  = (cnt_q == n_i - CNT_W'(1));
  assign cnt_o   = cnt_q;
  assign pulse_o = pulse_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= term_o;
      cnt_q   <= term_o ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cd_regs.sv
module cd_regs
  import cd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int FIELD_W  = 5,
  parameter int DIV_ADDR = 1,
  parameter int EN_ADDR  = 2,
  parameter int EN_BIT   = 0
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               term_i,
  output logic [FIELD_W-1:0] field_o,
  output logic               en_o,
  output logic               busy_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [FIELD_W-1:0] field_q, pend_q;
  logic               en_q, busy_q, done_q;
  logic [DATA_W-1:0]  rdata_q, rd_mux;
  logic               div_wr, en_wr, fits, apply;

  assign div_wr = wr_en_i && (addr_i == ADDR_W'(DIV_ADDR));
  assign en_wr  = wr_en_i && (addr_i == ADDR_W'(EN_ADDR));
  assign fits   = ((wdata_i >> FIELD_W) == '0);
  assign apply  = busy_q && !done_q && (!en_q || term_i);

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(STATUS_ADDR)) begin
      rd_mux[BUSY_HI:BUSY_LO] = {2{busy_q}};
    end else if (addr_i == ADDR_W'(DIV_ADDR)) begin
      rd_mux[FIELD_W-1:0] = field_q;
    end else if (addr_i == ADDR_W'(EN_ADDR)) begin
      rd_mux[EN_BIT] = en_q;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      field_q <= '0;
      pend_q  <= '0;
      en_q    <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (done_q) begin
        busy_q <= 1'b0;
        done_q <= 1'b0;
      end else if (apply) begin
        field_q <= pend_q;
        done_q  <= 1'b1;
      end
      if (div_wr && fits && !busy_q) begin
        pend_q <= wdata_i[FIELD_W-1:0];
        busy_q <= 1'b1;
      end
      if (en_wr) begin
        en_q <= wdata_i[EN_BIT];
      end
      if (rd_en_i) begin
        rdata_q <= rd_mux;
      end
    end
  end

  assign field_o = field_q;
  assign en_o    = en_q;
  assign busy_o  = busy_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int BASE_W   = 5,
  parameter int WIDE     = 0,
  parameter int PRE_LOG2 = 6,
  parameter int DIV_ADDR = 1,
  parameter int EN_ADDR  = 2,
  parameter int EN_BIT   = 0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              clk_en_o
);
  localparam int FIELD_W = BASE_W + WIDE;
  localparam int PLAIN_N = 1 << FIELD_W;
  localparam int PRE_N   = ((1 << BASE_W) - 1) << PRE_LOG2;
  localparam int MAX_N   = (WIDE != 0 && PRE_N > PLAIN_N) ? PRE_N : PLAIN_N;
  localparam int CNT_W   = $clog2(MAX_N + 1);

  logic [FIELD_W-1:0] field_q;
  logic               en_q, busy_q, term;
  logic [CNT_W-1:0]   n_eff, cnt;

  cd_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W),
    .DIV_ADDR(DIV_ADDR), .EN_ADDR(EN_ADDR), .EN_BIT(EN_BIT)
  ) regs_i (
    .clk_i(clk_i), .rst_i(rst_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .term_i(term),
    .field_o(field_q), .en_o(en_q), .busy_o(busy_q), .rdata_o(rdata_o)
  );

  cd_div_decode #(
    .BASE_W(BASE_W), .WIDE(WIDE), .PRE_LOG2(PRE_LOG2), .CNT_W(CNT_W)
  ) dec_i (
    .field_i(field_q), .n_o(n_eff)
  );

  cd_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_q), .n_i(n_eff),
    .term_o(term), .cnt_o(cnt), .pulse_o(clk_en_o)
  );
endmodule

// File: rtl/clkdiv_gate_chk.sv
module clkdiv_gate_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  parameter int FIELD_W  = 5,
  parameter int CNT_W    = 6,
  parameter int DIV_ADDR = 1
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic               clk_en,
  input logic               en_q,
  input logic               busy_q,
  input logic [FIELD_W-1:0] field_q,
  input logic               term,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   n_eff
);
  logic div_wr, too_big;
  assign div_wr  = wr_en && (addr == ADDR_W'(DIV_ADDR));
  assign too_big = ((wdata >> FIELD_W) != '0);

  // R7
  gated_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !clk_en);

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && n_eff != CNT_W'(1)) |=> !clk_en);

  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < n_eff);

  // R5
  reject_big_chk: assert property (@(posedge clk) disable iff (rst)
    (div_wr && too_big && !busy_q) |=> (!busy_q && $stable(field_q)));

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (div_wr && !too_big && !busy_q) |=> busy_q);

  // R9
  apply_point_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(field_q) |-> $past(!en_q || term));
endmodule

bind clkdiv_gate clkdiv_gate_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FIELD_W(FIELD_W),
  .CNT_W(CNT_W), .DIV_ADDR(DIV_ADDR)
) chk_i (
  .clk(clk_i), .rst(rst_i), .wr_en(wr_en_i), .addr(addr_i), .wdata(wdata_i),
  .clk_en(clk_en_o), .en_q(en_q), .busy_q(busy_q), .field_q(field_q),
  .term(term), .cnt(cnt), .n_eff(n_eff)
);

// File: tb/clkdiv_gate_tb_top.sv
module clkdiv_gate_ref #(
  parameter int BASE_W = 5,
  parameter int WIDE   = 0,
  parameter int EN_BIT = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic        pulse
);
  int cnt, field, pend;
  bit en, busy, done;

  function automatic int eff(int f);
    int lim = 1 << (BASE_W + WIDE);
    if (WIDE != 0 && f >= (1 << BASE_W)) begin
      if (f == (1 << BASE_W)) return lim;
      return (f - (1 << BASE_W)) * 64;
    end
    if (f == 0) return lim;
    return f;
  endfunction

  always @(posedge clk) begin : step
    int  nn;
    bit  last;
    if (rst) begin
      cnt <= 0; field <= 0; pend <= 0; en <= 0; busy <= 0; done <= 0; pulse <= 0;
    end else begin
      nn   = eff(field);
      last = (cnt == nn - 1);
      pulse <= en && last;
      cnt   <= en ? (last ? 0 : cnt + 1) : 0;
      if (done) begin
        busy <= 0; done <= 0;
      end else if (busy && (!en || last)) begin
        field <= pend; done <= 1;
      end
      if (wr_en && addr == 4'd1 && !busy && wdata < 32'(1 << (BASE_W + WIDE))) begin
        pend <= int'(wdata); busy <= 1;
      end
      if (wr_en && addr == 4'd2) en <= wdata[EN_BIT];
    end
  end
endmodule

module clkdiv_gate_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en [2];
  logic        rd_en [2];
  logic [3:0]  addr  [2];
  logic [31:0] wdata [2];
  logic [31:0] rdata [2];
  logic        cen   [2];
  logic        ref_p [2];
  int          cyc = 0;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          finished = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clkdiv_gate #(.WIDE(0), .EN_BIT(3)) dut_i (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en[0]), .rd_en_i(rd_en[0]),
    .addr_i(addr[0]), .wdata_i(wdata[0]), .rdata_o(rdata[0]), .clk_en_o(cen[0]));
  clkdiv_gate #(.WIDE(1), .EN_BIT(0)) dut_w_i (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en[1]), .rd_en_i(rd_en[1]),
    .addr_i(addr[1]), .wdata_i(wdata[1]), .rdata_o(rdata[1]), .clk_en_o(cen[1]));

  clkdiv_gate_ref #(.WIDE(0), .EN_BIT(3)) ref0_i (
    .clk(clk), .rst(rst), .wr_en(wr_en[0]), .addr(addr[0]), .wdata(wdata[0]), .pulse(ref_p[0]));
  clkdiv_gate_ref #(.WIDE(1), .EN_BIT(0)) ref1_i (
    .clk(clk), .rst(rst), .wr_en(wr_en[1]), .addr(addr[1]), .wdata(wdata[1]), .pulse(ref_p[1]));

  task automatic chk(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // R2 per-cycle comparison with the reference model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      for (int w = 0; w < 2; w++) chk(cen[w] === ref_p[w], "R2 model", int'(cen[w]), int'(ref_p[w]));
    end
  end

  task automatic wr(int w, int a, int d);
    @(negedge clk);
    wr_en[w] = 1'b1; addr[w] = 4'(a); wdata[w] = 32'(d);
    @(negedge clk);
    wr_en[w] = 1'b0;
  endtask

  task automatic rd(int w, int a, output int v);
    @(negedge clk);
    rd_en[w] = 1'b1; addr[w] = 4'(a);
    @(negedge clk);
    rd_en[w] = 1'b0;
    v = int'(rdata[w]);
  endtask

  task automatic wait_idle(int w);
    int v;
    for (int k = 0; k < 3000; k++) begin
      rd(w, 0, v);
      if (v == 0) return;
    end
    chk(0, "R8 busy never cleared", v, 0);
  endtask

  task automatic next_pulse(int w, output int t);
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!cen[w] && k < 5000);
    if (!cen[w]) chk(0, "R2 no pulse", 0, 1);
    t = cyc;
  endtask

  task automatic gap(int w, output int g);
    int t0, t1;
    next_pulse(w, t0);
    next_pulse(w, t1);
    g = t1 - t0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int v, g, t0, t1, c, cnt_p;
    for (int w = 0; w < 2; w++) begin
      wr_en[w] = 0; rd_en[w] = 0; addr[w] = 0; wdata[w] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(cen[0] == 1'b0, "R1 clk_en", int'(cen[0]), 0);
    rd(0, 0, v); chk(v == 0, "R1 R11 status", v, 0);
    rd(0, 1, v); chk(v == 0, "R1 R11 divisor", v, 0);
    rd(0, 2, v); chk(v == 0, "R1 R11 enable", v, 0);

    // R6 enable via bit 3, R3 default divisor 32
    wr(0, 2, 8);
    rd(0, 2, v); chk(v == 8, "R6 enable readback", v, 8);
    gap(0, g);   chk(g == 32, "R3 zero field narrow", g, 32);

    // R2 / R8 plain divisor 5
    wr(0, 1, 5);
    rd(0, 0, v); chk(v == 32'h18, "R8 busy after write", v, 32'h18);
    wait_idle(0);
    gap(0, g);   chk(g == 5, "R2 divide by 5", g, 5);

    wr(0, 1, 1); wait_idle(0);
    gap(0, g);   chk(g == 1, "R2 divide by 1", g, 1);

    // R5 out-of-range write rejected
    wr(0, 1, 37);
    rd(0, 0, v); chk(v == 0, "R5 no busy", v, 0);
    rd(0, 1, v); chk(v == 1, "R5 divisor kept", v, 1);

    // R9 / R10 alignment and write while busy
    wr(0, 1, 20); wait_idle(0);
    next_pulse(0, t0);
    wr(0, 1, 3);
    rd(0, 0, v); chk(v == 32'h18, "R8 busy pending", v, 32'h18);
    wr(0, 1, 7);
    next_pulse(0, t1); chk(t1 - t0 == 20, "R9 period not shortened", t1 - t0, 20);
    gap(0, g);   chk(g == 3, "R10 busy write ignored", g, 3);
    rd(0, 1, v); chk(v == 3, "R10 divisor readback", v, 3);

    // R6 other bits ignored, R7 gated off
    wr(0, 2, 32'hFFFF_FFF7);
    rd(0, 2, v); chk(v == 0, "R6 other bits ignored", v, 0);
    cnt_p = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (cen[0]) cnt_p++;
    end
    chk(cnt_p == 0, "R7 no pulses when gated", cnt_p, 0);
    wr(0, 1, 4); wait_idle(0);   // R9 applied while gated
    @(negedge clk);
    wr_en[0] = 1'b1; addr[0] = 4'd2; wdata[0] = 32'd8; c = cyc;
    @(negedge clk);
    wr_en[0] = 1'b0;
    next_pulse(0, t1); chk(t1 - c == 5, "R7 first pulse after enable", t1 - c, 5);

    // Wide build: R4, R3, R2, R5
    wr(1, 2, 1);
    wr(1, 1, 32'h22); wait_idle(1);
    gap(1, g); chk(g == 128, "R4 prescale 2x64", g, 128);
    wr(1, 1, 32'h20); wait_idle(1);
    gap(1, g); chk(g == 64, "R4 prescale zero low bits", g, 64);
    wr(1, 1, 0); wait_idle(1);
    gap(1, g); chk(g == 64, "R3 zero field wide", g, 64);
    wr(1, 1, 32'h1F); wait_idle(1);
    gap(1, g); chk(g == 31, "R2 wide plain 31", g, 31);
    wr(1, 1, 32'h40);
    rd(1, 0, v); chk(v == 0, "R5 wide no busy", v, 0);
    rd(1, 1, v); chk(v == 32'h1F, "R5 wide divisor kept", v, 32'h1F);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule